// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time clock. Software programs a 4-bit rate code and a 3-bit timebase selector into control register A. The block turns them into a reload count, expressed in ticks of a timebase strobe whose frequency is the parameter `TICK_HZ`. While the periodic-enable bit of control register B is set, a down-counter advances on each tick. Each time it expires, the block sets the periodic flag in status register C and raises the interrupt output. The counter is then reloaded with the period, so successive interrupts stay evenly spaced and do not drift.

Software services the interrupt by reading status register C. That read returns the flags together with a summary bit that is the OR of the three event flags, then clears the register and drops the interrupt line. Clearing the enable bit also drops the line at once. Writing register A, or changing the enable bit, restarts the countdown with a full period, so software can realign the interrupt phase.

All accesses use a simple byte-wide register port. Read data is registered and appears on the cycle after the read strobe.

Top module: `rtc_pit`

## Requirements
- R1: After reset, registers A, B and C read as 0x00, the interrupt output is low, and the read data is 0x00.
- R2: Register A sits at address 0x0A, B at 0x0B and C at 0x0C. A write to A keeps only the rate code in bits 3:0 and the timebase selector in bits 6:4, and bit 7 of A reads 0. Every other address reads 0x00 and ignores writes.
- R3: Rate code 0 produces no interrupt, however many ticks arrive.
- R4: A rate code k from 3 to 15 selects 2^(16-k) Hz. This gives a period of TICK_HZ/2^(16-k) ticks (8 ticks for code 3 and 32768 ticks for code 15 at the default TICK_HZ of 65536).
- R5: Timebase selector 010 chooses the slow timebase, and 000 or 001 chooses the fast one. Any other selector value keeps the previous choice, and the fast timebase is active after reset. Rate codes 1 and 2 select 256 Hz and 128 Hz on the slow timebase, and 32768 Hz and 16384 Hz on the fast one.
- R6: With enable on, the first expiry falls on the P-th tick after a reload, where P is the period in ticks, and every later expiry falls P ticks after the previous one. Each expiry sets PF (bit 6 of C) and raises the interrupt output from the cycle after the tick.
- R7: A write to register A reloads the countdown. A write to B that changes the enable bit (bit 6 of B) reloads it. A write to B that leaves the enable bit unchanged does not reload it.
- R8: While the enable bit is 0 the countdown does not advance. Writing B with the enable bit at 0 lowers the interrupt output on the next cycle and leaves the flags in C unchanged.
- R9: A read of C returns IRQF in bit 7 (the OR of PF, AF and UF), PF in bit 6, AF in bit 5, UF in bit 4, and zeros in bits 3:0. The read then clears C and lowers the interrupt output. If an expiry happens in the same cycle as the read, the read returns the old value, and the expiry still sets PF and raises the interrupt.
- R10: Writing C loads AF from bit 5, UF from bit 4 and PF from bit 6, and does not change the interrupt output.
- R11: Cycles without a tick leave the countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Periodic interrupt output |

## Verification
The bench measures periods at the exact tick boundary: the line must still be low one tick before the expiry and high right after it. An off-by-one counter, or one that is zeroed instead of reloaded, fails one of those two samples. It programs rate codes 1 and 2 on both timebases and with a "keep" selector. A decoder that ignores the timebase, or resets it on an unknown selector, then shows a period 128 times too short or too long. It checks the reload rules by rewriting A and B in mid-count, and races a status read against an expiry. A design that lets the clear win that race loses an interrupt. Further checks cover rate 0, the enable bit turned off while the line is high, and idle cycles without ticks. A design that counts on the clock instead of the tick, or fails to mask on the enable bit, raises the line too early.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;

   localparam int REG_W    = 8;
   localparam int RS_W     = 4;
   localparam int DV_W     = 3;
   localparam int N_RATES  = 1 << RS_W;

   // register addresses (fixed: software decodes them)
   localparam int ADDR_CTRL_A = 10;
   localparam int ADDR_CTRL_B = 11;
   localparam int ADDR_STAT_C = 12;

   // bit positions
   localparam int EN_BIT   = 6;
   localparam int IRQF_BIT = 7;
   localparam int PF_BIT   = 6;
   localparam int AF_BIT   = 5;
   localparam int UF_BIT   = 4;

   // timebase selector codes
   localparam logic [DV_W-1:0] TB_SLOW   = 3'b010;
   localparam logic [DV_W-1:0] TB_FAST_0 = 3'b000;
   localparam logic [DV_W-1:0] TB_FAST_1 = 3'b001;

   // interrupt frequency in Hz for a rate code, 0 when disabled
   function automatic longint unsigned rate_hz(input int unsigned code, input bit slow);
      if (code == 0) return 0;
      if (code == 1) return slow ? 64'd256 : 64'd32768;
      if (code == 2) return slow ? 64'd128 : 64'd16384;
      return 64'd1 << (16 - code);
   endfunction

   // period in ticks of the timebase strobe
   function automatic longint unsigned period_ticks(input int unsigned code, input bit slow,
                                                    input longint unsigned tick_hz);
      longint unsigned hz;
      hz = rate_hz(code, slow);
      if (hz == 0) return 0;
      return tick_hz / hz;
   endfunction

endpackage

// File: rtl/rtc_pit_rate_dec.sv
module rtc_pit_rate_dec
   import rtc_pit_pkg::*;
#(
   parameter int unsigned TICK_HZ = 65536,
   parameter int          CNT_W   = 16
)(
   input  logic [RS_W-1:0]  code,
   input  logic             slow,
   output logic [CNT_W-1:0] period
);

   logic [CNT_W-1:0] tab_fast [N_RATES];
   logic [CNT_W-1:0] tab_slow [N_RATES];

   for (genvar k = 0; k < N_RATES; k++) begin : g_rate
      localparam longint unsigned PF_K = period_ticks(k, 1'b0, TICK_HZ);
      localparam longint unsigned PS_K = period_ticks(k, 1'b1, TICK_HZ);
      assign tab_fast[k] = CNT_W'(PF_K);
      assign tab_slow[k] = CNT_W'(PS_K);
   end

   assign period = slow ? tab_slow[code] : tab_fast[code];

endmodule

// File: rtl/rtc_pit_countdown.sv
module rtc_pit_countdown #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             reload,
   input  logic [CNT_W-1:0] period,
   output logic             fire
);

   logic [CNT_W-1:0] cnt_q;
   logic             active;

   assign active = en && tick && (period != '0);
   assign fire   = active && !reload && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (reload)  cnt_q <= period;
      else if (fire)    cnt_q <= period;
      else if (active)  cnt_q <= cnt_q - CNT_W'(1);
   end

   // counter never exceeds the period it was loaded from
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |-> cnt_q <= period);

   // expiry adds a full period back
   assert_fire_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cnt_q == $past(period));

   // no tick, no movement
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reload) |=> $stable(cnt_q));

   // disabled counter holds
   assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_pit_regs.sv
module rtc_pit_regs
   import rtc_pit_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              fire,
   output logic [REG_W-1:0]  rdata,
   output logic              irq,
   output logic [RS_W-1:0]   rate_nxt,
   output logic              slow_nxt,
   output logic              en,
   output logic              reload
);

   logic [RS_W-1:0]  rs_q;
   logic [DV_W-1:0]  dv_q;
   logic             slow_q;
   logic [REG_W-1:0] ctl_b_q;
   logic             pf_q, af_q, uf_q;
   logic             irq_q;
   logic [REG_W-1:0] rdata_q;

   logic sel_a, sel_b, sel_c;
   logic a_wr, b_wr, c_wr, c_rd;
   logic slow_sel;
   logic en_off_wr;
   logic [REG_W-1:0] stat_val, rd_mux;
   logic [DV_W-1:0]  dv_in;

   assign sel_a = (addr == ADDR_W'(ADDR_CTRL_A));
   assign sel_b = (addr == ADDR_W'(ADDR_CTRL_B));
   assign sel_c = (addr == ADDR_W'(ADDR_STAT_C));
   assign a_wr  = wr_en && sel_a;
   assign b_wr  = wr_en && sel_b;
   assign c_wr  = wr_en && sel_c;
   assign c_rd  = rd_en && sel_c;

   assign dv_in = wdata[RS_W +: DV_W];

   always_comb begin
      if (dv_in == TB_SLOW)                               slow_sel = 1'b1;
      else if (dv_in == TB_FAST_0 || dv_in == TB_FAST_1) slow_sel = 1'b0;
      else                                                slow_sel = slow_q;
   end

   assign rate_nxt  = a_wr ? wdata[RS_W-1:0] : rs_q;
   assign slow_nxt  = a_wr ? slow_sel : slow_q;
   assign en        = ctl_b_q[EN_BIT];
   assign en_off_wr = b_wr && !wdata[EN_BIT];
   assign reload    = a_wr || (b_wr && (wdata[EN_BIT] != ctl_b_q[EN_BIT]));

   always_comb begin
      stat_val           = '0;
      stat_val[IRQF_BIT] = pf_q | af_q | uf_q;
      stat_val[PF_BIT]   = pf_q;
      stat_val[AF_BIT]   = af_q;
      stat_val[UF_BIT]   = uf_q;
   end

   always_comb begin
      rd_mux = '0;
      if (sel_a)      rd_mux = {1'b0, dv_q, rs_q};
      else if (sel_b) rd_mux = ctl_b_q;
      else if (sel_c) rd_mux = stat_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_q    <= '0;
         dv_q    <= '0;
         slow_q  <= 1'b0;
         ctl_b_q <= '0;
      end else begin
         if (a_wr) begin
            rs_q   <= wdata[RS_W-1:0];
            dv_q   <= dv_in;
            slow_q <= slow_sel;
         end
         if (b_wr) ctl_b_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_q <= 1'b0;
         af_q <= 1'b0;
         uf_q <= 1'b0;
      end else begin
         if (c_wr) begin
            pf_q <= wdata[PF_BIT];
            af_q <= wdata[AF_BIT];
            uf_q <= wdata[UF_BIT];
         end else if (c_rd) begin
            pf_q <= 1'b0;
            af_q <= 1'b0;
            uf_q <= 1'b0;
         end
         if (fire) pf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (en_off_wr) irq_q <= 1'b0;
      else if (fire)      irq_q <= 1'b1;
      else if (c_rd)      irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;
   assign irq   = irq_q;

   assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));

   assert_en_off_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_off_wr |=> !irq_q);

   assert_fire_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !en_off_wr) |=> (irq_q && pf_q));

   assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && !fire) |=> (!irq_q && !pf_q && !af_q && !uf_q));

   assert_low_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd |=> rdata_q[3:0] == 4'h0);

   assert_cwr_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && !fire) |=> $stable(irq_q));

endmodule

// File: rtl/rtc_pit.sv
module rtc_pit
   import rtc_pit_pkg::*;
#(
   parameter int unsigned TICK_HZ = 65536,
   parameter int          ADDR_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq
);

   localparam int CNT_W = $clog2(TICK_HZ / 2 + 1);

   if (TICK_HZ < 32768) begin : g_bad_tick
      $error("rtc_pit: TICK_HZ must be at least 32768");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_pit: ADDR_W must be at least 4");
   end

   logic [RS_W-1:0]  rate_nxt;
   logic             slow_nxt;
   logic             en;
   logic             reload;
   logic             fire;
   logic [CNT_W-1:0] period;

   rtc_pit_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .fire     (fire),
      .rdata    (rdata),
      .irq      (irq),
      .rate_nxt (rate_nxt),
      .slow_nxt (slow_nxt),
      .en       (en),
      .reload   (reload)
   );

   rtc_pit_rate_dec #(.TICK_HZ(TICK_HZ), .CNT_W(CNT_W)) dec_i (
      .code   (rate_nxt),
      .slow   (slow_nxt),
      .period (period)
   );

   rtc_pit_countdown #(.CNT_W(CNT_W)) cd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .en     (en),
      .reload (reload),
      .period (period),
      .fire   (fire)
   );

   // rate code 0 decodes to no period and must never expire
   assert_rate0_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_nxt == '0) |-> !fire);

   // expiry only with the enable bit set and a tick present
   assert_fire_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (en && tick));

endmodule

// File: tb/rtc_pit_tb_top.sv
module rtc_pit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   rtc_pit dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .irq   (irq)
   );

   // monitor: pops expected read data after each read edge
   always begin
      @(posedge clk);
      if (rd_en) begin
         @(negedge clk);
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read: actual %02h expected none", rdata);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               n_bad++;
               $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
            end
         end
      end
   end

   task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, input logic [7:0] e, input string t);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_cmp++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
      end
   endtask

   // expects expiry exactly on the p-th tick
   task automatic period_chk(input int p, input string t);
      ticks(p - 1);
      chk_irq(1'b0, t);
      ticks(1);
      chk_irq(1'b1, t);
      reg_rd(4'hC, 8'hC0, t);
      chk_irq(1'b0, t);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      n_cmp++;
      if (rdata !== 8'h00) begin
         n_bad++;
         $display("FAIL R1 rdata: actual %02h expected 00", rdata);
      end
      reg_rd(4'hA, 8'h00, "R1 reg A");
      reg_rd(4'hB, 8'h00, "R1 reg B");
      reg_rd(4'hC, 8'h00, "R1 reg C");

      // R2 map and field masking
      reg_wr(4'h3, 8'h55);
      reg_rd(4'h3, 8'h00, "R2 unmapped");
      reg_wr(4'hA, 8'hFF);
      reg_rd(4'hA, 8'h7F, "R2 A fields");

      // R4 / R6 code 3, slow timebase: 8 ticks
      reg_wr(4'hA, 8'h23);
      reg_wr(4'hB, 8'h40);
      period_chk(8, "R4 code3 first");
      reg_rd(4'hC, 8'h00, "R9 C cleared");
      period_chk(8, "R6 code3 repeat");

      // R5 timebase dependence of codes 1 and 2
      reg_wr(4'hA, 8'h21);
      period_chk(256, "R5 code1 slow");
      reg_wr(4'hA, 8'h01);
      period_chk(2, "R5 code1 fast");
      reg_wr(4'hA, 8'h72);
      period_chk(4, "R5 code2 keep fast");
      reg_wr(4'hA, 8'h22);
      period_chk(512, "R5 code2 slow");

      // R7 reloads
      reg_wr(4'hA, 8'h24);
      ticks(10);
      reg_wr(4'hA, 8'h24);
      period_chk(16, "R7 A write reload");
      ticks(10);
      reg_wr(4'hB, 8'h41);
      period_chk(6, "R7 B same enable no reload");
      ticks(10);
      reg_wr(4'hB, 8'h00);
      reg_wr(4'hB, 8'h40);
      period_chk(16, "R7 B toggle reload");

      // R8 enable off
      ticks(16);
      chk_irq(1'b1, "R8 pre");
      reg_wr(4'hB, 8'h00);
      chk_irq(1'b0, "R8 drop");
      reg_rd(4'hC, 8'hC0, "R8 flags kept");
      ticks(40);
      chk_irq(1'b0, "R8 no count");
      reg_rd(4'hC, 8'h00, "R8 no flag");

      // R3 rate 0
      reg_wr(4'hA, 8'h20);
      reg_wr(4'hB, 8'h40);
      ticks(100);
      chk_irq(1'b0, "R3 rate0");
      reg_rd(4'hC, 8'h00, "R3 rate0 flags");

      // R10 write to C
      reg_wr(4'hC, 8'h30);
      chk_irq(1'b0, "R10 irq");
      reg_rd(4'hC, 8'hB0, "R10 C load");
      reg_rd(4'hC, 8'h00, "R10 C clear");

      // R9 expiry racing a status read
      reg_wr(4'hA, 8'h23);
      ticks(7);
      tick = 1'b1; rd_en = 1'b1; addr = 4'hC;
      exp_q.push_back(8'h00); tag_q.push_back("R9 race old value");
      @(negedge clk);
      tick = 1'b0; rd_en = 1'b0;
      chk_irq(1'b1, "R9 race irq");
      reg_rd(4'hC, 8'hC0, "R9 race PF");

      // R11 idle cycles without tick
      reg_wr(4'hA, 8'h23);
      repeat (20) @(negedge clk);
      chk_irq(1'b0, "R11 idle");
      period_chk(8, "R11 after idle");

      // R4 other codes
      reg_wr(4'hA, 8'h26);
      period_chk(64, "R4 code6");
      reg_wr(4'hA, 8'h2F);
      period_chk(32768, "R4 code15");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      summary();
   end

endmodule